// File: doc/BRIEF.md
# Bus-Master Interrupt Aggregator

This block gathers the interrupt conditions raised by bus-master transfers and presents them to the local side on one active-low interrupt line. There are four sources:

- the read transfer count reaching zero;
- the write transfer count reaching zero;
- an error seen during a bus-master transaction;
- a mailbox event, which shares the same line.

Each source has a pending bit and an enable bit, both held in one combined control/status register. A source pulses its event input for a cycle, and the matching pending bit is latched.

The interrupt line falls when any source that is both enabled and pending appears. Software reads the register to learn which source fired. It then writes ones to the pending bits it has serviced, and the line returns high once nothing enabled is left pending. The counters and error detection that produce the events live outside this block.

Top module: `bm_irq_combiner`

## Requirements
- R1: After reset all pending bits and all enable bits are 0 and `irqN` is 1.
- R2: An event pulse on `srcEvent[i]` sampled at a clock edge sets pending bit i at that edge. This happens whether or not source i is enabled. Source indices: 0 read count zero, 1 write count zero, 2 bus-master error, 3 mailbox.
- R3: `regRdData` bits [3:0] are the pending bits and bits [7:4] are the enable bits, each field in source index order.
- R4: A write (`regWrEn` high at an edge) loads the enable bits from `regWrData[7:4]`.
- R5: In a write, a 1 in `regWrData[i]` (i in 0..3) clears pending bit i, and a 0 leaves it unchanged. Without a write, a pending bit changes only through an event.
- R6: When an event and a clear for the same source arrive in the same cycle, the pending bit ends up set.
- R7: `irqN` is registered. After each edge it equals the NOR, over all sources, of (pending AND enabled) as they stood before that edge. This makes it lag the register contents by one cycle.
- R8: A pending source whose enable bit is 0 does not pull `irqN` low. Setting its enable later does pull the line low.
- R9: The mailbox source (index 3) drives `irqN` and shows in the register exactly like the transfer sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEvent | input | 4 | One-cycle event pulses, one per source |
| regWrEn | input | 1 | Write strobe for the control/status register |
| regWrData | input | 8 | Write data: [7:4] enables, [3:0] write-one-to-clear |
| regRdData | output | 8 | Read data: [7:4] enables, [3:0] pending |
| irqN | output | 1 | Active-low combined interrupt |

## Verification
Pending and enable bits become visible on `regRdData` immediately after the edge that samples an event or a write. `irqN` follows one edge later, because it is registered from those bits.

The bench drives inputs on the falling edge and keeps a behavioural model that updates on the rising edge. It compares both outputs at every falling edge, so each result is sampled in exactly the cycle it is due. The directed checks confirm both the one-cycle lag of the interrupt line and its settling on the following cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int SRC_COUNT = 4;
  localparam int REG_W     = 2 * SRC_COUNT;
  localparam int SRC_RD_ZERO = 0;
  localparam int SRC_WR_ZERO = 1;
  localparam int SRC_BM_ERR  = 2;
  localparam int SRC_MAILBOX = 3;

  typedef struct packed {
    logic                 loadEnable;
    logic [SRC_COUNT-1:0] enableValue;
    logic [SRC_COUNT-1:0] clearMask;
    logic [SRC_COUNT-1:0] setMask;
  } irqStrobes_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter bit HAS_MAILBOX = 1'b1
) (
  input  logic [SRC_COUNT-1:0] srcEvent,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  output irqStrobes_t          strobes
);
  logic [SRC_COUNT-1:0] srcMask;

  // Mailbox lane is either live or tied off by the parameter.
  generate
    for (genvar i = 0; i < SRC_COUNT; i++) begin : g_mask
      if (i == SRC_MAILBOX) begin : g_mbox
        assign srcMask[i] = HAS_MAILBOX;
      end else begin : g_xfer
        assign srcMask[i] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    strobes.setMask     = srcEvent & srcMask;
    strobes.loadEnable  = regWrEn;
    strobes.enableValue = regWrData[REG_W-1:SRC_COUNT] & srcMask;
    strobes.clearMask   = regWrEn ? (regWrData[SRC_COUNT-1:0] & srcMask)
                                  : '0;
  end
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  irqStrobes_t      strobes,
  output logic [REG_W-1:0] regRdData,
  output logic             irqN
);
  logic [SRC_COUNT-1:0] pendBits;
  logic [SRC_COUNT-1:0] enBits;

  generate
    for (genvar i = 0; i < SRC_COUNT; i++) begin : g_src
      // Set has priority over a same-cycle write-one-to-clear.
      always_ff @(posedge clk) begin
        if (!rstN) begin
          pendBits[i] <= 1'b0;
        end else if (strobes.setMask[i]) begin
          pendBits[i] <= 1'b1;
        end else if (strobes.clearMask[i]) begin
          pendBits[i] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBits <= '0;
      irqN   <= 1'b1;
    end else begin
      if (strobes.loadEnable) enBits <= strobes.enableValue;
      irqN <= ~|(pendBits & enBits);
    end
  end

  assign regRdData = {enBits, pendBits};
endmodule

// File: rtl/bm_irq_combiner.sv
module bm_irq_combiner
  import irq_agg_pkg::*;
#(
  parameter bit HAS_MAILBOX = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] srcEvent,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  output logic                 irqN
);
  irqStrobes_t strobes;

  irq_agg_ctrl #(.HAS_MAILBOX(HAS_MAILBOX)) i_ctrl (
    .srcEvent (srcEvent),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .strobes  (strobes)
  );

  irq_agg_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regRdData(regRdData),
    .irqN     (irqN)
  );
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
  import irq_agg_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [SRC_COUNT-1:0] srcEvent,
  input logic                 regWrEn,
  input logic [REG_W-1:0]     regWrData,
  input logic [REG_W-1:0]     regRdData,
  input logic                 irqN
);
  generate
    for (genvar i = 0; i < SRC_COUNT; i++) begin : g_chk
      AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rstN)
        srcEvent[i] |=> regRdData[i]); // R6
      AST_CLEAR_BIT: assert property (@(posedge clk) disable iff (!rstN)
        (regWrEn && regWrData[i] && !srcEvent[i]) |=> !regRdData[i]); // R5
      AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        (!srcEvent[i] && !(regWrEn && regWrData[i])) |=> $stable(regRdData[i])); // R5
    end
  endgenerate

  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regRdData[REG_W-1:SRC_COUNT] == $past(regWrData[REG_W-1:SRC_COUNT]))); // R4

  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(regRdData[REG_W-1:SRC_COUNT])); // R4

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqN == !(|($past(regRdData[SRC_COUNT-1:0]) &
                          $past(regRdData[REG_W-1:SRC_COUNT]))))); // R7
endmodule

bind bm_irq_combiner irq_agg_checker i_irq_agg_checker (
  .clk      (clk),
  .rstN     (rstN),
  .srcEvent (srcEvent),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .irqN     (irqN)
);

// File: tb/test_bm_irq_combiner.sv
module test_bm_irq_combiner;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] srcEvent = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqN;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string curReq = "R7";

  // Behavioural reference state
  logic [3:0] mPend = '0;
  logic [3:0] mEn = '0;
  logic       mIrqN = 1'b1;

  bm_irq_combiner i_bm_irq_combiner (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqN(irqN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      mPend = '0; mEn = '0; mIrqN = 1'b1;
    end else begin
      mIrqN = ((mPend & mEn) == 4'b0);
      mPend = (mPend & ~(regWrEn ? regWrData[3:0] : 4'b0)) | srcEvent;
      if (regWrEn) mEn = regWrData[7:4];
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check({curReq, " model rd"}, regRdData, {mEn, mPend});
      check({curReq, " model irqN"}, irqN, mIrqN);
    end
  end

  task automatic step(input logic [3:0] ev, input logic we, input logic [7:0] wd);
    srcEvent = ev; regWrEn = we; regWrData = wd;
    @(negedge clk);
    srcEvent = '0; regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rd", regRdData, 8'h00);
    check("R1 reset irqN", irqN, 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {irqN, regRdData}, 9'h100);

    curReq = "R2";
    step(4'b0001, 0, 8'h00);
    check("R2 latch while disabled", regRdData, 8'h01);
    step(4'b0000, 0, 8'h00);
    check("R8 disabled pending keeps irqN high", irqN, 1);

    curReq = "R4";
    step(4'b0000, 1, 8'h10);
    check("R4 enable loaded", regRdData, 8'h11);
    check("R7 irqN lags one cycle", irqN, 1);
    step(4'b0000, 0, 8'h00);
    check("R8 enabling pulls irqN low", irqN, 0);
    check("R3 field layout", regRdData, 8'h11);

    curReq = "R5";
    step(4'b0000, 1, 8'h11);
    check("R5 w1c clears bit0", regRdData, 8'h10);
    check("R7 irqN still low one cycle", irqN, 0);
    step(4'b0000, 0, 8'h00);
    check("R7 irqN returns high", irqN, 1);

    curReq = "R6";
    step(4'b0010, 1, 8'h32);
    check("R6 event beats clear", regRdData, 8'h32);
    step(4'b0100, 1, 8'h30);
    check("R5 zero leaves pending", regRdData, 8'h36);
    step(4'b0000, 0, 8'h00);
    check("R7 write-count source low", irqN, 0);

    curReq = "R9";
    step(4'b0000, 1, 8'h86);
    check("R9 only mailbox enabled", regRdData, 8'h80);
    step(4'b0000, 0, 8'h00);
    check("R9 no mailbox pending", irqN, 1);
    step(4'b1000, 0, 8'h00);
    check("R9 mailbox latched", regRdData, 8'h88);
    step(4'b0000, 0, 8'h00);
    check("R9 mailbox drives irqN", irqN, 0);
    step(4'b0000, 1, 8'h48);
    step(4'b0000, 0, 8'h00);
    check("R2 error source cleared state", {irqN, regRdData}, 9'h140);

    curReq = "R7";
    for (int n = 0; n < 400; n++) begin
      logic [3:0] ev;
      logic       we;
      logic [7:0] wd;
      ev = 4'($urandom) & 4'($urandom);
      we = ($urandom % 3) == 0;
      wd = 8'($urandom);
      step(ev, we, wd);
    end
    step(4'b0000, 0, 8'h00);
    finish_run();
  end
endmodule